// File: doc/BRIEF.md
# Register Rename Unit

This block turns up to four instructions per cycle from architectural register names into physical register tags. It keeps three pieces of state:

- a map table that records which physical register currently holds each architectural register;
- a circular free list of physical registers that are not in use;
- a ring of map snapshots, one for each rename group still in flight.

Every valid slot that writes a register takes a fresh tag from the free list. The slot also reports the tag that its destination displaced. That displaced tag travels with the instruction and comes back through the retire port when the instruction retires in order.

When the back end finds a misprediction or an exception, it names the snapshot of the faulting group on the recover port. In one edge the block restores both the map and the free-list read pointer. This squashes the faulting group and every younger group, and reclaims all the registers those groups took. A controller with two named states governs this:

- **ST_RUN** is the normal renaming state.
- **ST_FLUSH** is one dead cycle after a recovery, during which no group is accepted.
- Transition **RUN→FLUSH** is taken on any cycle with `rec_valid` high.
- Transition **FLUSH→RUN** is taken on the next cycle unless another recovery arrives; in that case the block stays in FLUSH.

Top module: `reg_rename_unit`

## Requirements
- R1: After reset, architectural register i maps to physical register i, `ready` is high, and the free list holds tags 32..79 in ascending order, so the first allocations are 32, 33, 34, ...
- R2: A group fires when `ready` is high and any `in_valid` bit is set. Each slot with valid=1 and write=1 takes the next free tag, slots in ascending order (slot 0 first). Slots that do not write take no tag and report `out_dst` = 0 and `out_old` = 0. An invalid slot reports 0 on all four of its tag outputs.
- R3: Each valid slot looks up two source registers in the same cycle, giving eight reads per group.
- R4: A source that names the destination of an earlier writing slot in the same group takes that slot's new tag. The nearest earlier writer wins. A later slot never feeds an earlier one.
- R5: `out_old` is the tag that the destination mapped to just before this slot. This includes a new tag given to an earlier slot of the same group.
- R6: Each `ret_valid` slot appends its `ret_old` tag to the tail of the free list, in slot order. Such a tag is handed out again only after every entry that was already free.
- R7: If the group needs more tags than are free, `ready` is low and nothing is renamed or consumed that cycle.
- R8: Each fired group saves a snapshot at ring index `out_ckpt`. Indices are handed out 0, 1, 2, ... modulo 8. With 8 snapshots in flight, `ready` is low. A `ret_group_end` pulse releases the oldest snapshot.
- R9: When `rec_valid` is high with index k, `ready` is low that cycle. The map and the free-list read pointer return to their values from before group k, and groups k and younger are dropped. `ready` stays low for one more cycle (ST_FLUSH). The next group then receives index k and reuses the reclaimed tags first.
- R10: Rename results are combinational in the cycle a group is presented. Map updates take effect at the clock edge, so they are seen by the next group.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 4 | Per-slot valid |
| in_wr | input | 4 | Per-slot "writes a destination" |
| in_src1 | input | 4x5 | First source register per slot |
| in_src2 | input | 4x5 | Second source register per slot |
| in_dst | input | 4x5 | Destination register per slot |
| ready | output | 1 | Group accepted this cycle if any slot is valid |
| out_src1 | output | 4x7 | Physical tag of first source |
| out_src2 | output | 4x7 | Physical tag of second source |
| out_dst | output | 4x7 | New destination tag |
| out_old | output | 4x7 | Tag displaced by the destination |
| out_ckpt | output | 3 | Snapshot index of this group |
| ret_valid | input | 4 | Per-slot retire valid |
| ret_old | input | 4x7 | Displaced tag being freed |
| ret_group_end | input | 1 | Oldest group fully retired; release its snapshot |
| rec_valid | input | 1 | Recover request |
| rec_ckpt | input | 3 | Snapshot index to restore |

## Verification
All rename outputs and `ready` are due in the same cycle as the stimulus. The bench therefore drives each group at the falling edge and samples the outputs 1 ns later, before the rising edge that commits the group. State effects appear one edge later:

- map updates, pushes from retirement and snapshot release show up in the outputs for the next group presented;
- a recovery drops `ready` in the same cycle and again in the single flush cycle after it;
- the restored map and reclaimed tags are first visible two cycles after the request.

The bench checks each of these effects at the cycle when it is due.

// File: rtl/rnm_pkg.sv
package rnm_pkg;
    typedef enum logic {
        ST_RUN   = 1'b0,
        ST_FLUSH = 1'b1
    } rnm_state_e;
endpackage

// File: rtl/rnm_free_list.sv
module rnm_free_list #(
    parameter int FREE_N = 48,
    parameter int ARCH   = 32,
    parameter int W      = 4,
    parameter int PW     = 7,
    parameter int PTRW   = 7,
    parameter int NW     = 3
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NW-1:0]          pop_cnt,
    input  logic [W-1:0]           push_en,
    input  logic [W-1:0][PW-1:0]   push_tag,
    input  logic                   restore_en,
    input  logic [PTRW-1:0]        restore_head,
    output logic [W-1:0][PW-1:0]   peek,
    output logic [PTRW-1:0]        head_o,
    output logic [PTRW-1:0]        free_cnt
);
    localparam int IW    = PTRW - 1;
    localparam int DEPTH = 2 ** IW;

    logic [PW-1:0]   mem_q [DEPTH];
    logic [PTRW-1:0] head_q, tail_q;
    logic [IW-1:0]   push_idx [W];
    logic [NW-1:0]   push_total;

    assign head_o   = head_q;
    assign free_cnt = tail_q - head_q;

    always_comb begin
        for (int i = 0; i < W; i++) begin
            peek[i] = mem_q[head_q[IW-1:0] + IW'(i)];
        end
    end

    always_comb begin
        push_total = '0;
        for (int i = 0; i < W; i++) begin
            push_idx[i] = tail_q[IW-1:0] + IW'(push_total);
            if (push_en[i]) push_total = push_total + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head_q <= '0;
            tail_q <= PTRW'(FREE_N);
            for (int i = 0; i < DEPTH; i++) begin
                mem_q[i] <= (i < FREE_N) ? PW'(ARCH + i) : '0;
            end
        end else begin
            for (int i = 0; i < W; i++) begin
                if (push_en[i]) mem_q[push_idx[i]] <= push_tag[i];
            end
            tail_q <= tail_q + PTRW'(push_total);
            head_q <= restore_en ? restore_head : head_q + PTRW'(pop_cnt);
        end
    end

    a_r7_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
        !restore_en |-> (PTRW'(pop_cnt) <= free_cnt));

    a_r6_free_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        free_cnt <= PTRW'(FREE_N));
endmodule

// File: rtl/rnm_map_table.sv
module rnm_map_table #(
    parameter int ARCH  = 32,
    parameter int AW    = 5,
    parameter int PW    = 7,
    parameter int W     = 4,
    parameter int CKPTS = 8,
    parameter int CW    = 3,
    parameter int PTRW  = 7
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [W-1:0]              upd_en,
    input  logic [W-1:0][AW-1:0]      upd_arch,
    input  logic [W-1:0][PW-1:0]      upd_tag,
    input  logic                      save_en,
    input  logic [CW-1:0]             save_idx,
    input  logic [PTRW-1:0]           save_head,
    input  logic                      restore_en,
    input  logic [CW-1:0]             restore_idx,
    output logic [ARCH-1:0][PW-1:0]   map_o,
    output logic [PTRW-1:0]           restore_head_o
);
    logic [ARCH-1:0][PW-1:0] map_q;
    logic [ARCH-1:0][PW-1:0] snap_q      [CKPTS];
    logic [PTRW-1:0]         snap_head_q [CKPTS];

    assign map_o          = map_q;
    assign restore_head_o = snap_head_q[restore_idx];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int a = 0; a < ARCH; a++) map_q[a] <= PW'(a);
        end else if (restore_en) begin
            map_q <= snap_q[restore_idx];
        end else begin
            for (int i = 0; i < W; i++) begin
                if (upd_en[i]) map_q[upd_arch[i]] <= upd_tag[i];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (save_en) begin
            snap_q[save_idx]      <= map_q;
            snap_head_q[save_idx] <= save_head;
        end
    end
endmodule

// File: rtl/rnm_group_xlate.sv
module rnm_group_xlate #(
    parameter int ARCH = 32,
    parameter int AW   = 5,
    parameter int PW   = 7,
    parameter int W    = 4,
    parameter int NW   = 3
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     go,
    input  logic [W-1:0]             valid,
    input  logic [W-1:0]             wr,
    input  logic [W-1:0][AW-1:0]     src1,
    input  logic [W-1:0][AW-1:0]     src2,
    input  logic [W-1:0][AW-1:0]     dst,
    input  logic [ARCH-1:0][PW-1:0]  map,
    input  logic [W-1:0][PW-1:0]     peek,
    output logic [W-1:0]             wr_en,
    output logic [NW-1:0]            need,
    output logic [W-1:0][PW-1:0]     src1_tag,
    output logic [W-1:0][PW-1:0]     src2_tag,
    output logic [W-1:0][PW-1:0]     dst_tag,
    output logic [W-1:0][PW-1:0]     old_tag
);
    logic [W-1:0][PW-1:0] alloc;

    always_comb begin
        need = '0;
        for (int i = 0; i < W; i++) begin
            wr_en[i] = valid[i] & wr[i];
            alloc[i] = peek[need[$clog2(W)-1:0]];
            if (wr_en[i]) need = need + 1'b1;
        end
    end

    always_comb begin
        for (int j = 0; j < W; j++) begin
            logic [PW-1:0] s1, s2, od;
            s1 = map[src1[j]];
            s2 = map[src2[j]];
            od = map[dst[j]];
            for (int k = 0; k < W; k++) begin
                if (k < j && wr_en[k]) begin
                    if (dst[k] == src1[j]) s1 = alloc[k];
                    if (dst[k] == src2[j]) s2 = alloc[k];
                    if (dst[k] == dst[j])  od = alloc[k];
                end
            end
            src1_tag[j] = valid[j] ? s1 : '0;
            src2_tag[j] = valid[j] ? s2 : '0;
            dst_tag[j]  = wr_en[j] ? alloc[j] : '0;
            old_tag[j]  = wr_en[j] ? od : '0;
        end
    end

    generate
        for (genvar a = 0; a < W; a++) begin : g_pair
            for (genvar b = a + 1; b < W; b++) begin : g_other
                a_r2_distinct_dst: assert property (@(posedge clk) disable iff (!rst_n)
                    (go && wr_en[a] && wr_en[b]) |-> (dst_tag[a] != dst_tag[b]));
            end
            a_r5_fresh_not_old: assert property (@(posedge clk) disable iff (!rst_n)
                (go && wr_en[a]) |-> (dst_tag[a] != old_tag[a]));
        end
    endgenerate
endmodule

// File: rtl/reg_rename_unit.sv
module reg_rename_unit
    import rnm_pkg::*;
#(
    parameter int SLOTS     = 4,
    parameter int ARCH_REGS = 32,
    parameter int PHYS_REGS = 80,
    parameter int CKPTS     = 8,
    localparam int AW       = $clog2(ARCH_REGS),
    localparam int PW       = $clog2(PHYS_REGS),
    localparam int CW       = $clog2(CKPTS)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [SLOTS-1:0]          in_valid,
    input  logic [SLOTS-1:0]          in_wr,
    input  logic [SLOTS-1:0][AW-1:0]  in_src1,
    input  logic [SLOTS-1:0][AW-1:0]  in_src2,
    input  logic [SLOTS-1:0][AW-1:0]  in_dst,
    output logic                      ready,
    output logic [SLOTS-1:0][PW-1:0]  out_src1,
    output logic [SLOTS-1:0][PW-1:0]  out_src2,
    output logic [SLOTS-1:0][PW-1:0]  out_dst,
    output logic [SLOTS-1:0][PW-1:0]  out_old,
    output logic [CW-1:0]             out_ckpt,
    input  logic [SLOTS-1:0]          ret_valid,
    input  logic [SLOTS-1:0][PW-1:0]  ret_old,
    input  logic                      ret_group_end,
    input  logic                      rec_valid,
    input  logic [CW-1:0]             rec_ckpt
);
    localparam int FREE_N = PHYS_REGS - ARCH_REGS;
    localparam int PTRW   = $clog2(FREE_N) + 1;
    localparam int NW     = $clog2(SLOTS + 1);

    rnm_state_e state_q, state_d;

    logic [ARCH_REGS-1:0][PW-1:0] map;
    logic [SLOTS-1:0][PW-1:0]     peek;
    logic [SLOTS-1:0]             wr_en;
    logic [NW-1:0]                need;
    logic [PTRW-1:0]              fl_head, fl_free, snap_head;
    logic                         fire;
    logic [CW-1:0]                ck_head_q, ck_tail;
    logic [CW:0]                  ck_cnt_q;

    assign fire     = ready & (|in_valid);
    assign ck_tail  = ck_head_q + CW'(ck_cnt_q);
    assign out_ckpt = ck_tail;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_RUN;
        else        state_q <= state_d;
    end

    // next state and outputs
    always_comb begin
        state_d = state_q;
        ready   = 1'b0;
        unique case (state_q)
            ST_RUN: begin
                if (rec_valid) begin
                    state_d = ST_FLUSH;
                end else begin
                    ready = (ck_cnt_q < (CW+1)'(CKPTS)) && (PTRW'(need) <= fl_free);
                end
            end
            ST_FLUSH: begin
                state_d = rec_valid ? ST_FLUSH : ST_RUN;
            end
            default: state_d = ST_RUN;
        endcase
    end

    // snapshot ring bookkeeping
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ck_head_q <= '0;
            ck_cnt_q  <= '0;
        end else begin
            ck_head_q <= ck_head_q + CW'(ret_group_end);
            if (rec_valid) begin
                ck_cnt_q <= {1'b0, CW'(rec_ckpt - ck_head_q)} - (CW+1)'(ret_group_end);
            end else begin
                ck_cnt_q <= ck_cnt_q + (CW+1)'(fire) - (CW+1)'(ret_group_end);
            end
        end
    end

    rnm_group_xlate #(.ARCH(ARCH_REGS), .AW(AW), .PW(PW), .W(SLOTS), .NW(NW)) u_xlate (
        .clk(clk), .rst_n(rst_n), .go(fire),
        .valid(in_valid), .wr(in_wr), .src1(in_src1), .src2(in_src2), .dst(in_dst),
        .map(map), .peek(peek), .wr_en(wr_en), .need(need),
        .src1_tag(out_src1), .src2_tag(out_src2), .dst_tag(out_dst), .old_tag(out_old)
    );

    rnm_map_table #(.ARCH(ARCH_REGS), .AW(AW), .PW(PW), .W(SLOTS), .CKPTS(CKPTS),
                    .CW(CW), .PTRW(PTRW)) u_map (
        .clk(clk), .rst_n(rst_n),
        .upd_en(wr_en & {SLOTS{fire}}), .upd_arch(in_dst), .upd_tag(out_dst),
        .save_en(fire), .save_idx(ck_tail), .save_head(fl_head),
        .restore_en(rec_valid), .restore_idx(rec_ckpt),
        .map_o(map), .restore_head_o(snap_head)
    );

    rnm_free_list #(.FREE_N(FREE_N), .ARCH(ARCH_REGS), .W(SLOTS), .PW(PW),
                    .PTRW(PTRW), .NW(NW)) u_free (
        .clk(clk), .rst_n(rst_n),
        .pop_cnt(fire ? need : '0), .push_en(ret_valid), .push_tag(ret_old),
        .restore_en(rec_valid), .restore_head(snap_head),
        .peek(peek), .head_o(fl_head), .free_cnt(fl_free)
    );

    a_r8_ckpt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        ck_cnt_q <= (CW+1)'(CKPTS));

    a_r9_flush_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FLUSH && !rec_valid) |=> (state_q == ST_RUN));
endmodule

// File: tb/reg_rename_unit_bench.sv
`timescale 1ns/1ps
module reg_rename_unit_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic [3:0]      in_valid, in_wr, ret_valid;
    logic [3:0][4:0] in_src1, in_src2, in_dst;
    logic [3:0][6:0] out_src1, out_src2, out_dst, out_old, ret_old;
    logic [2:0]      out_ckpt, rec_ckpt;
    logic            ready, ret_group_end, rec_valid;

    int checks = 0;
    int errors = 0;

    reg_rename_unit u_reg_rename_unit (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_wr(in_wr),
        .in_src1(in_src1), .in_src2(in_src2), .in_dst(in_dst), .ready(ready),
        .out_src1(out_src1), .out_src2(out_src2), .out_dst(out_dst), .out_old(out_old),
        .out_ckpt(out_ckpt), .ret_valid(ret_valid), .ret_old(ret_old),
        .ret_group_end(ret_group_end), .rec_valid(rec_valid), .rec_ckpt(rec_ckpt)
    );

    typedef struct packed {
        logic [3:0]      v;
        logic [3:0]      w;
        logic [3:0][4:0] s1;
        logic [3:0][4:0] s2;
        logic [3:0][4:0] d;
        logic [3:0][6:0] e1;
        logic [3:0][6:0] e2;
        logic [3:0][6:0] ed;
        logic [3:0][6:0] eo;
        logic [2:0]      eck;
    } vec_t;

    // slot fields listed {slot3, slot2, slot1, slot0}
    localparam vec_t TBL [3] = '{
        '{4'b1111, 4'b1111,
          {5'd3, 5'd3, 5'd1, 5'd2}, {5'd1, 5'd1, 5'd3, 5'd3}, {5'd2, 5'd1, 5'd2, 5'd3},
          {7'd32, 7'd32, 7'd1, 7'd2}, {7'd34, 7'd1, 7'd32, 7'd3},
          {7'd35, 7'd34, 7'd33, 7'd32}, {7'd33, 7'd1, 7'd2, 7'd3}, 3'd0},
        '{4'b1011, 4'b1101,
          {5'd7, 5'd4, 5'd2, 5'd1}, {5'd2, 5'd4, 5'd5, 5'd3}, {5'd7, 5'd7, 5'd9, 5'd2},
          {7'd7, 7'd0, 7'd36, 7'd34}, {7'd36, 7'd0, 7'd5, 7'd32},
          {7'd37, 7'd0, 7'd0, 7'd36}, {7'd7, 7'd0, 7'd0, 7'd35}, 3'd1},
        '{4'b1000, 4'b1000,
          {5'd0, 5'd0, 5'd0, 5'd0}, {5'd31, 5'd0, 5'd0, 5'd0}, {5'd0, 5'd0, 5'd0, 5'd0},
          {7'd0, 7'd0, 7'd0, 7'd0}, {7'd31, 7'd0, 7'd0, 7'd0},
          {7'd38, 7'd0, 7'd0, 7'd0}, {7'd0, 7'd0, 7'd0, 7'd0}, 3'd2}
    };

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic idle();
        in_valid = '0; in_wr = '0; in_src1 = '0; in_src2 = '0; in_dst = '0;
        ret_valid = '0; ret_old = '0; ret_group_end = 1'b0;
        rec_valid = 1'b0; rec_ckpt = '0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        idle();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check("R1 ready after reset", ready, 1);

        // table of groups, R1 R2 R3 R4 R5 R10 R8
        for (int r = 0; r < 3; r++) begin
            @(negedge clk);
            idle();
            in_valid = TBL[r].v; in_wr = TBL[r].w;
            in_src1 = TBL[r].s1; in_src2 = TBL[r].s2; in_dst = TBL[r].d;
            #1;
            check("R2 ready", ready, 1);
            check("R8 ckpt index", out_ckpt, TBL[r].eck);
            for (int s = 0; s < 4; s++) begin
                check("R3/R4 src1", out_src1[s], TBL[r].e1[s]);
                check("R3/R4 src2", out_src2[s], TBL[r].e2[s]);
                check("R2 dst", out_dst[s], TBL[r].ed[s]);
                check("R5 old", out_old[s], TBL[r].eo[s]);
            end
        end

        // R9 recovery to snapshot 1
        @(negedge clk);
        idle();
        rec_valid = 1'b1; rec_ckpt = 3'd1;
        #1;
        check("R9 ready low on recover", ready, 0);
        @(negedge clk);
        idle();
        in_valid = 4'b0001; in_wr = 4'b0001;
        in_src1[0] = 5'd2; in_src2[0] = 5'd7; in_dst[0] = 5'd9;
        #1;
        check("R9 flush cycle ready low", ready, 0);
        @(negedge clk);
        #1;
        check("R9 ready after flush", ready, 1);
        check("R9 restored r2", out_src1[0], 35);
        check("R9 restored r7", out_src2[0], 7);
        check("R9 reclaimed tag", out_dst[0], 36);
        check("R9 old r9", out_old[0], 9);
        check("R9 ckpt reused", out_ckpt, 1);

        // R6 retire two tags and release oldest snapshot
        @(negedge clk);
        idle();
        ret_valid = 4'b0011; ret_old[0] = 7'd3; ret_old[1] = 7'd2; ret_group_end = 1'b1;

        // drain the free list down to one entry
        for (int g = 0; g < 11; g++) begin
            @(negedge clk);
            idle();
            in_valid = 4'b1111; in_wr = 4'b1111; ret_group_end = 1'b1;
            in_dst = {5'd13, 5'd12, 5'd11, 5'd10};
            #1;
            check("R2 drain ready", ready, 1);
            if (g == 10) begin
                check("R6 dst slot0", out_dst[0], 77);
                check("R6 dst slot1", out_dst[1], 78);
                check("R6 dst slot2", out_dst[2], 79);
                check("R6 retired tag after older free", out_dst[3], 3);
            end
        end

        // R7 stall: two writers, one free tag
        @(negedge clk);
        idle();
        in_valid = 4'b0011; in_wr = 4'b0011; in_dst[0] = 5'd14; in_dst[1] = 5'd15;
        #1;
        check("R7 stall ready", ready, 0);
        @(negedge clk);
        idle();
        in_valid = 4'b0001; in_wr = 4'b0001; in_dst[0] = 5'd14;
        #1;
        check("R7 one writer ready", ready, 1);
        check("R7 no tag consumed while stalled", out_dst[0], 2);
        @(negedge clk);
        #1;
        check("R7 empty free list stalls", ready, 0);

        // R8 fill snapshots with non-writing groups (2 in flight now)
        for (int g = 0; g < 6; g++) begin
            @(negedge clk);
            idle();
            in_valid = 4'b0001; in_wr = 4'b0000;
            #1;
            check("R8 ready below limit", ready, 1);
            check("R2 non-writer dst zero", out_dst[0], 0);
        end
        @(negedge clk);
        #1;
        check("R8 full snapshots stall", ready, 0);
        @(negedge clk);
        idle();
        ret_group_end = 1'b1;
        @(negedge clk);
        idle();
        in_valid = 4'b0001;
        #1;
        check("R8 release reopens", ready, 1);
        @(negedge clk);
        idle();
        @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule